// File: doc/BRIEF.md
# Phase-Frequency Detector With Reference Divider and Lock Flag

This block sits at the digital heart of an integer-N synthesizer loop. A programmable divider turns the oscillator clock into a reference tick. A tri-state phase-frequency detector then compares that tick with a feedback tick from the loop's main divider. The detector issues pump-up and pump-down requests that a charge pump turns into current. It also raises a flag whenever neither request is active, which is the lock indication.

All events are single-cycle strobes synchronous to the oscillator clock. When a tick arrives on one side, that side's flag rises and stays up until the other side's tick arrives. Once both flags are up, they are held together for a fixed clear delay and then dropped together. A locked loop therefore still produces short, equal pulses on both requests every compare period. The lock flag dips low for exactly as long as any request is active.

A polarity input adapts the block to oscillators whose frequency falls with control voltage. When it is low, the roles of the two requests are swapped, and the monitor output shows the feedback tick instead of the reference tick. The pump-up request is active low, matching an open-drain driver that pulls low or lets go.

Top module: `pfd_synth`

## Requirements
- R1: While reset is held, pump_up_n_o is 1, pump_dn_o is 0 and lock_o is 1; with fc_i high, mon_o is 0.
- R2: The reference divider counts ratio_i oscillator clocks per reference tick. Each tick is high for one clock. The first tick is visible ratio_i+2 clocks after reset release, two of those clocks being the reset synchronizer.
- R3: A ratio_i below 3 (0, 1 or 2) divides by 3.
- R4: A detector flag raised by a tick stays high until the opposite tick arrives. It then falls 2 clocks later, so a lead of d clocks gives a pulse d+2 clocks wide on the leading side.
- R5: When both flags are high, both stay high for exactly 2 clocks and then clear together. Ticks on both sides in the same clock therefore give 2-clock pulses on both requests.
- R6: With fc_i=1 the reference-side flag drives pump-up (pump_up_n_o=0) and the feedback-side flag drives pump_dn_o=1. With fc_i=0 these two roles are exchanged.
- R7: mon_o carries the reference tick when fc_i=1 and follows fp_i when fc_i=0.
- R8: lock_o is low exactly in the clocks where either request is active. For a lead of d clocks it is low for |d|+2 clocks per compare period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ratio_i | input | 14 | Reference divide ratio (values below 3 act as 3) |
| fp_i | input | 1 | Feedback divider tick, one clock wide |
| fc_i | input | 1 | Polarity select; 1 = direct, 0 = swapped |
| pump_up_n_o | output | 1 | Pump-up request, active low (open-drain style) |
| pump_dn_o | output | 1 | Pump-down request, active high |
| mon_o | output | 1 | Monitor of the selected comparator input |
| lock_o | output | 1 | High when no request is active |

## Verification
The hardest condition to reach from the ports is an exact phase relation between the internally generated reference tick and the externally driven feedback tick. This matters most for coincident ticks and leads of one clock either way, where the shared clear window decides the pulse widths.

The stimulus counts clocks from reset release and predicts the cycle of every reference tick arithmetically from the ratio and the two synchronizer stages. It then places the feedback tick at offsets from -3 to +3 clocks, under both polarities, and integrates each request over one compare period.

Separate runs measure the tick spacing at the clamped ratios, at the minimum legal ratio, and at the 14-bit maximum.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;
  localparam int unsigned RATIO_W   = 14;
  localparam int unsigned MIN_RATIO = 3;
  localparam int unsigned CLR_DLY   = 2;
  localparam int unsigned SYNC_LEN  = 2;

  typedef enum logic {
    POL_SWAP   = 1'b0,
    POL_DIRECT = 1'b1
  } pol_e;

  typedef struct packed {
    logic ref_side;
    logic fb_side;
  } flag_t;
endpackage

// File: rtl/pfd_rst_sync.sv
`timescale 1ns/1ps
module pfd_rst_sync #(
  parameter int unsigned STAGES = 2  // must be at least 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pfd_ref_div.sv
`timescale 1ns/1ps
module pfd_ref_div #(
  parameter int unsigned RATIO_W   = 14,
  parameter int unsigned MIN_RATIO = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               fr_o
);
  localparam logic [RATIO_W-1:0] MIN_R = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] ONE   = RATIO_W'(1);

  logic [RATIO_W-1:0] cnt_q, cnt_d, last_idx, eff_ratio;
  logic               fr_q, fr_d, wrap;

  always_comb begin
    eff_ratio = (ratio_i < MIN_R) ? MIN_R : ratio_i;
    last_idx  = eff_ratio - ONE;
    wrap      = (cnt_q >= last_idx);
    cnt_d     = wrap ? '0 : cnt_q + ONE;
    fr_d      = wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      fr_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      fr_q  <= fr_d;
    end
  end

  assign fr_o = fr_q;

  // R2
  fr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_q |=> !fr_q);

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(ratio_i) && (cnt_q <= last_idx)) |=> (cnt_q <= last_idx));
endmodule

// File: rtl/pfd_core.sv
`timescale 1ns/1ps
module pfd_core
  import pfd_pkg::*;
#(
  parameter int unsigned CLR_DLY = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ref_hit_i,
  input  logic  fb_hit_i,
  output flag_t flags_o
);
  localparam int unsigned   CW       = (CLR_DLY > 1) ? $clog2(CLR_DLY) : 1;
  localparam logic [CW-1:0] CLR_LAST = CW'(CLR_DLY - 1);

  flag_t         flag_q, flag_d;
  logic [CW-1:0] clr_q, clr_d;
  logic          both;

  always_comb begin
    both   = flag_q.ref_side & flag_q.fb_side;
    flag_d = flag_q;
    clr_d  = clr_q;
    if (both) begin
      if (clr_q == CLR_LAST) begin
        flag_d = '0;
        clr_d  = '0;
      end else begin
        clr_d = clr_q + CW'(1);
      end
    end else begin
      flag_d.ref_side = flag_q.ref_side | ref_hit_i;
      flag_d.fb_side  = flag_q.fb_side  | fb_hit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      clr_q  <= '0;
    end else begin
      flag_q <= flag_d;
      clr_q  <= clr_d;
    end
  end

  assign flags_o = flag_q;

  // R4
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q.ref_side && !flag_q.fb_side) |=> flag_q.ref_side);

  // R4
  fb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q.fb_side && !flag_q.ref_side) |=> flag_q.fb_side);

  // R5
  joint_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q.ref_side && !flag_q.fb_side && ref_hit_i && fb_hit_i)
      |=> (flag_q.ref_side && flag_q.fb_side));

  // R5
  joint_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q.ref_side) |-> $fell(flag_q.fb_side));
endmodule

// File: rtl/pfd_synth.sv
`timescale 1ns/1ps
module pfd_synth
  import pfd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               fp_i,
  input  logic               fc_i,
  output logic               pump_up_n_o,
  output logic               pump_dn_o,
  output logic               mon_o,
  output logic               lock_o
);
  logic  rst_n_int;
  logic  fr_tick;
  flag_t flags;
  pol_e  pol;
  logic  up_req, dn_req;

  pfd_rst_sync #(.STAGES(SYNC_LEN)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  pfd_ref_div #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)) u_ref_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .ratio_i (ratio_i),
    .fr_o    (fr_tick)
  );

  pfd_core #(.CLR_DLY(CLR_DLY)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .ref_hit_i (fr_tick),
    .fb_hit_i  (fp_i),
    .flags_o   (flags)
  );

  always_comb begin
    pol = pol_e'(fc_i);
    unique case (pol)
      POL_DIRECT: begin
        up_req = flags.ref_side;
        dn_req = flags.fb_side;
        mon_o  = fr_tick;
      end
      default: begin
        up_req = flags.fb_side;
        dn_req = flags.ref_side;
        mon_o  = fp_i;
      end
    endcase
    pump_up_n_o = ~up_req;
    pump_dn_o   = dn_req;
    lock_o      = ~(flags.ref_side | flags.fb_side);
  end

  // R8
  lock_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !lock_o |-> (!pump_up_n_o || pump_dn_o));

  // R1
  idle_reset_chk: assert property (@(posedge clk_i)
    !rst_n_int |-> (pump_up_n_o && !pump_dn_o && lock_o));
endmodule

// File: tb/pfd_synth_bench.sv
`timescale 1ns/1ps
module pfd_synth_bench;
  localparam int R_MAIN = 16;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [13:0] ratio;
  logic        fp, fc;
  logic        pump_up_n, pump_dn, mon, lock;
  int          cyc;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  pfd_synth u_pfd_synth (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .ratio_i     (ratio),
    .fp_i        (fp),
    .fc_i        (fc),
    .pump_up_n_o (pump_up_n),
    .pump_dn_o   (pump_dn),
    .mon_o       (mon),
    .lock_o      (lock)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ratio_run(input int rv, input int eff, input string req);
    int first, second;
    rst_ni = 1'b0; fp = 1'b0; fc = 1'b1; ratio = 14'(rv);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    first = -1; second = -1;
    for (int n = 0; n < 2 * eff + 20 && second < 0; n++) begin
      @(negedge clk);
      if (mon) begin
        if (first < 0) first = cyc;
        else            second = cyc;
      end
    end
    chk(first == eff + 2, req, "first reference tick cycle", first, eff + 2);
    chk(second - first == eff, req, "reference tick spacing", second - first, eff);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; ratio = 14'(R_MAIN); fc = 1'b1; fp = 1'b0;
    repeat (4) @(negedge clk);
    // R1: idle state under reset
    chk(pump_up_n == 1'b1, "R1", "pump_up_n in reset", pump_up_n, 1);
    chk(pump_dn == 1'b0, "R1", "pump_dn in reset", pump_dn, 0);
    chk(lock == 1'b1, "R1", "lock in reset", lock, 1);
    chk(mon == 1'b0, "R1", "mon in reset", mon, 0);
    rst_ni = 1'b1;

    // Sweep feedback lead d = -3..3 under both polarities (R4 R5 R6 R7 R8)
    for (int k = 1; k <= 14; k++) begin
      int d, up_w, dn_w, lk_w, mon_at, ref_w, fb_w, mon_exp, ad;
      bit pol;
      pol = (k <= 7);
      d   = ((k - 1) % 7) - 3;
      while (cyc != R_MAIN * k - 2) @(negedge clk);
      fc = pol;
      up_w = 0; dn_w = 0; lk_w = 0; mon_at = -1;
      for (int i = 0; i < R_MAIN; i++) begin
        int c;
        c = cyc;
        up_w += (pump_up_n == 1'b0) ? 1 : 0;
        dn_w += (pump_dn == 1'b1) ? 1 : 0;
        lk_w += (lock == 1'b0) ? 1 : 0;
        if (mon && mon_at < 0) mon_at = c;
        fp = (c == R_MAIN * k + 2 + d);
        @(negedge clk);
      end
      ad      = (d < 0) ? -d : d;
      ref_w   = (d >= 0) ? d + 2 : 2;
      fb_w    = (d <= 0) ? ad + 2 : 2;
      mon_exp = pol ? R_MAIN * k + 2 : R_MAIN * k + 3 + d;
      if (d == 0) begin
        // R5: coincident ticks give equal minimum pulses
        chk(up_w == 2 && dn_w == 2, "R5", "coincident pulse widths up*10+dn",
            up_w * 10 + dn_w, 22);
      end
      // R4 R6: widths of pump requests
      chk(up_w == (pol ? ref_w : fb_w), pol ? "R4/R6 direct" : "R4/R6 swapped",
          "pump-up low cycles", up_w, pol ? ref_w : fb_w);
      chk(dn_w == (pol ? fb_w : ref_w), pol ? "R4/R6 direct" : "R4/R6 swapped",
          "pump-down high cycles", dn_w, pol ? fb_w : ref_w);
      // R8
      chk(lk_w == ad + 2, "R8", "lock low cycles", lk_w, ad + 2);
      // R7
      chk(mon_at == mon_exp, "R7", "monitor pulse cycle", mon_at, mon_exp);
    end

    // R3: prohibited ratios act as 3
    ratio_run(1, 3, "R3");
    ratio_run(0, 3, "R3");
    ratio_run(2, 3, "R3");
    // R2: legal ratios including both ends
    ratio_run(3, 3, "R2");
    ratio_run(7, 7, "R2");
    ratio_run(16383, 16383, "R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule